// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is an 18-bit first-in first-out buffer. The producer and the consumer each run on their own free-running clock. Words enter on the write clock while the active-low write strobe is low. They leave on the read clock while the active-low read strobe is low. A separate active-low output enable chooses between two kinds of read. With the enable low, the read presents the word on the output bus. With the enable high, the read discards the word, and the bus drive-enable output drops.

Five active-low status outputs report the fill level: full, empty, more-than-half, almost-full and almost-empty. The two "almost" thresholds live in offset registers. Software writes them through the write port by holding the active-low load strobe low during enabled write cycles. The first such cycle sets the almost-empty offset and the second sets the almost-full offset. Pointers cross between the clock domains as Gray code through two-flop synchronizers. The reset input is active high and synchronous. It must be held for several edges of both clocks.

Top module: `dcf_prog_flags`

## Requirements
- R1: While reset is held and right after it, empty_n and aempty_n are 0, full_n, afull_n and half_n are 1, rd_data_oe is 0, and both offsets are 7.
- R2: Each word written with wr_en_n=0, load_n=1 and full_n=1 is read back in write order. The word is on rd_data after the read-clock edge at which rd_en_n=0, oe_n=0 and empty_n=1.
- R3: full_n is 0 when DEPTH words are stored. A write attempted while full_n=0 stores nothing and moves no pointer.
- R4: empty_n is 0 when no word is stored. A read attempted while empty_n=0 consumes nothing, so the next written word is the next word read.
- R5: A read with oe_n=1 consumes a word but leaves rd_data unchanged. The next presented read returns the word after the skipped one.
- R6: rd_data_oe equals the inverse of oe_n as sampled at the previous read-clock edge.
- R7: Once the block is quiet, half_n is 0 exactly when the stored count is greater than DEPTH/2.
- R8: Once the block is quiet, aempty_n is 0 exactly when the stored count is at most the almost-empty offset.
- R9: Once the block is quiet, afull_n is 0 exactly when the stored count is at least DEPTH minus the almost-full offset.
- R10: While load_n=0, each enabled write loads wr_data[AW-1:0] into an offset register instead of storing data. The first cycle loads the almost-empty offset and the second loads the almost-full offset. A write cycle with load_n=1 returns the sequence to the almost-empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held across both clocks |
| wr_en_n | input | 1 | Active-low write strobe |
| load_n | input | 1 | Active-low offset load select |
| wr_data | input | 18 | Write data or offset value |
| rd_en_n | input | 1 | Active-low read strobe |
| oe_n | input | 1 | Active-low output enable; high skips the word |
| rd_data | output | 18 | Read data |
| rd_data_oe | output | 1 | Drive enable for the output bus |
| full_n | output | 1 | Active-low full |
| afull_n | output | 1 | Active-low almost full |
| half_n | output | 1 | Active-low more than half full |
| empty_n | output | 1 | Active-low empty |
| aempty_n | output | 1 | Active-low almost empty |

## Verification
The hardest state to reach is a write or a read attempted at the exact moment the opposite flag is set. This has to happen while the other domain is still moving its pointer and the synchronized copy lags behind. The random phase runs the write side on a 5 ns clock and the read side on a 7 ns clock, with a read on only every other read cycle. The buffer therefore fills up and pushes against full many times while reads drain it through the synchronizers. Directed steps then fill to each threshold edge: one word either side of half, of both almost thresholds (default and reloaded), and of full and empty.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} ofs_sel_e;
  localparam int DEF_OFS = 7;
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int W  = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int WORDS = 1 << AW;
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 18,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_n,
  input  logic          load_n,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rgray_sync,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] ae_off,
  output logic          full_n,
  output logic          afull_n,
  output logic          half_n
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
  localparam logic [AW-1:0] DEF_P   = AW'(DEF_OFS);

  logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt_nx;
  logic [AW-1:0] af_off;
  ofs_sel_e      sel;
  logic          req, ld;

  always_comb begin
    rbin_s[PW-1] = rgray_sync[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_sync[i];
  end

  assign req     = !wr_en_n;
  assign ld      = req && !load_n;
  assign we      = req && load_n && full_n;
  assign wbin_nx = wbin + PW'(we);
  assign cnt_nx  = wbin_nx - rbin_s;
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
      half_n  <= 1'b1;
      ae_off  <= DEF_P;
      af_off  <= DEF_P;
      sel     <= SEL_AE;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wbin_nx ^ (wbin_nx >> 1);
      full_n  <= (cnt_nx != DEPTH_P);
      afull_n <= !(cnt_nx >= (DEPTH_P - {1'b0, af_off}));
      half_n  <= !(cnt_nx > HALF_P);
      if (ld) begin
        if (sel == SEL_AE) begin
          ae_off <= wr_data[AW-1:0];
          sel    <= SEL_AF;
        end else begin
          af_off <= wr_data[AW-1:0];
          sel    <= SEL_AE;
        end
      end else if (req) begin
        sel <= SEL_AE;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wbin - rbin_s) <= DEPTH_P); // R3
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !wr_en_n) |=> $stable(wgray)); // R3
  AST_LOAD_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !wr_en_n) |=> $stable(wgray)); // R10
  AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray))); // R2
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en_n,
  input  logic          oe_n,
  input  logic [PW-1:0] wgray_sync,
  input  logic [AW-1:0] ae_off,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          data_oe,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [AW-1:0] DEF_P   = AW'(DEF_OFS);

  logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_nx;
  logic [AW-1:0] ae_q;
  logic          pop;

  always_comb begin
    wbin_s[PW-1] = wgray_sync[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_sync[i];
  end

  assign pop     = !rd_en_n && empty_n;
  assign re      = pop && !oe_n;
  assign rbin_nx = rbin + PW'(pop);
  assign cnt_nx  = wbin_s - rbin_nx;
  assign raddr   = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      ae_q     <= DEF_P;
      data_oe  <= 1'b0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      ae_q     <= ae_off;
      data_oe  <= !oe_n;
      empty_n  <= (cnt_nx != '0);
      aempty_n <= !(cnt_nx <= {1'b0, ae_q});
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wbin_s - rbin) <= DEPTH_P); // R4
  AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && !rd_en_n) |=> $stable(rgray)); // R4
  AST_SKIP_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !data_oe); // R6
  AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rgray ^ $past(rgray))); // R2
endmodule

// File: rtl/dcf_prog_flags.sv
module dcf_prog_flags #(
  parameter int DW    = 18,
  parameter int DEPTH = 256
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst,
  input  logic          wr_en_n,
  input  logic          load_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_n,
  input  logic          oe_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_data_oe,
  output logic          full_n,
  output logic          afull_n,
  output logic          half_n,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          we, re;
  logic [AW-1:0] waddr, raddr, ae_off;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

  dcf_wr_ctl #(.DEPTH(DEPTH), .DW(DW)) u_wr (
    .clk(wr_clk), .rst(rst), .wr_en_n(wr_en_n), .load_n(load_n),
    .wr_data(wr_data), .rgray_sync(rgray_s), .we(we), .waddr(waddr),
    .wgray(wgray), .ae_off(ae_off), .full_n(full_n), .afull_n(afull_n),
    .half_n(half_n)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst(rst), .rd_en_n(rd_en_n), .oe_n(oe_n),
    .wgray_sync(wgray_s), .ae_off(ae_off), .re(re), .raddr(raddr),
    .rgray(rgray), .data_oe(rd_data_oe), .empty_n(empty_n),
    .aempty_n(aempty_n)
  );

  dcf_sync2 #(.W(PW)) u_w2r (.clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s));
  dcf_sync2 #(.W(PW)) u_r2w (.clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s));

  dcf_ram #(.W(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(re), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/dcf_prog_flags_tb.sv
`timescale 1ns/1ps
module dcf_prog_flags_tb;
  localparam int DW = 18;
  localparam int DEPTH = 256;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
  logic wr_en_n = 1'b1, load_n = 1'b1, rd_en_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_data_oe, full_n, afull_n, half_n, empty_n, aempty_n;

  int checks = 0, fails = 0;
  int ae_exp = 7, af_exp = 7;
  logic [DW-1:0] q[$];
  logic [DW-1:0] held;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  dcf_prog_flags #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en_n(wr_en_n),
    .load_n(load_n), .wr_data(wr_data), .rd_en_n(rd_en_n), .oe_n(oe_n),
    .rd_data(rd_data), .rd_data_oe(rd_data_oe), .full_n(full_n),
    .afull_n(afull_n), .half_n(half_n), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_full_n(int n);   return n != DEPTH;               endfunction
  function automatic bit exp_empty_n(int n);  return n != 0;                   endfunction
  function automatic bit exp_half_n(int n);   return !(n > DEPTH / 2);         endfunction
  function automatic bit exp_aempty_n(int n); return !(n <= ae_exp);           endfunction
  function automatic bit exp_afull_n(int n);  return !(n >= DEPTH - af_exp);   endfunction

  task automatic check_flags(input string ctx);
    int n = q.size();
    check(full_n == exp_full_n(n),     {"R3 full_n ", ctx},   full_n,   exp_full_n(n));
    check(empty_n == exp_empty_n(n),   {"R4 empty_n ", ctx},  empty_n,  exp_empty_n(n));
    check(half_n == exp_half_n(n),     {"R7 half_n ", ctx},   half_n,   exp_half_n(n));
    check(aempty_n == exp_aempty_n(n), {"R8 aempty_n ", ctx}, aempty_n, exp_aempty_n(n));
    check(afull_n == exp_afull_n(n),   {"R9 afull_n ", ctx},  afull_n,  exp_afull_n(n));
  endtask

  task automatic wr_cycle(input bit en, input bit ld, input logic [DW-1:0] d);
    bit ok;
    @(negedge wr_clk);
    ok = full_n;
    wr_en_n = !en; load_n = !ld; wr_data = d;
    @(posedge wr_clk);
    if (en && !ld && ok) q.push_back(d);
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wr_en_n = 1'b1; load_n = 1'b1;
  endtask

  task automatic rd_cycle(input bit en, input bit oe, input string tag);
    bit ok;
    logic [DW-1:0] e;
    @(negedge rd_clk);
    ok = empty_n;
    rd_en_n = !en; oe_n = !oe;
    @(posedge rd_clk);
    @(negedge rd_clk);
    rd_en_n = 1'b1;
    if (en && ok) begin
      e = q.pop_front();
      if (oe) begin
        check(rd_data == e, {tag, " rd_data"}, rd_data, e);
        check(rd_data_oe == 1'b1, "R6 rd_data_oe on", rd_data_oe, 1);
      end
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge wr_clk);
    repeat (6) @(posedge rd_clk);
    @(negedge rd_clk);
  endtask

  task automatic fill_to(input int n);
    while (q.size() < n) wr_cycle(1'b1, 1'b0, DW'($urandom));
    wr_idle();
    settle();
  endtask

  task automatic drain();
    while (q.size() > 0) rd_cycle(1'b1, 1'b1, "R2");
    settle();
  endtask

  initial begin
    #800us;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (10) @(posedge rd_clk);
    @(negedge rd_clk);
    check(rd_data_oe == 1'b0, "R1 rd_data_oe in reset", rd_data_oe, 0);
    check_flags("R1 in reset");
    rst = 1'b0;
    settle();
    check_flags("R1 after reset");

    // default thresholds and full
    fill_to(7);   check_flags("count 7");
    fill_to(8);   check_flags("count 8");
    fill_to(128); check_flags("count 128");
    fill_to(129); check_flags("count 129");
    fill_to(248); check_flags("count 248");
    fill_to(249); check_flags("count 249");
    fill_to(256); check_flags("count 256");
    for (int i = 0; i < 5; i++) wr_cycle(1'b1, 1'b0, DW'(18'h3F000 + i));
    wr_idle();
    settle();
    check_flags("R3 writes while full");
    drain();
    check_flags("drained");

    // read while empty ignored
    for (int i = 0; i < 4; i++) rd_cycle(1'b1, 1'b1, "R4");
    check(empty_n == 1'b0, "R4 empty after blocked reads", empty_n, 0);
    wr_cycle(1'b1, 1'b0, 18'h2AAAA);
    wr_idle();
    settle();
    rd_cycle(1'b1, 1'b1, "R4 next word after blocked reads");
    settle();

    // read skip
    wr_cycle(1'b1, 1'b0, 18'h00111);
    wr_cycle(1'b1, 1'b0, 18'h00222);
    wr_cycle(1'b1, 1'b0, 18'h00333);
    wr_idle();
    settle();
    rd_cycle(1'b1, 1'b1, "R5 first");
    held = rd_data;
    rd_cycle(1'b1, 1'b0, "R5 skipped");
    check(rd_data == held, "R5 rd_data held on skip", rd_data, held);
    check(rd_data_oe == 1'b0, "R6 rd_data_oe off on skip", rd_data_oe, 0);
    rd_cycle(1'b1, 1'b1, "R5 after skip");
    settle();
    check_flags("after skip");

    // offset load: ae=3, af=2
    wr_cycle(1'b1, 1'b1, 18'd3);
    wr_cycle(1'b1, 1'b1, 18'd2);
    wr_idle();
    ae_exp = 3; af_exp = 2;
    settle();
    check_flags("R10 load stores nothing");
    fill_to(3);   check_flags("R10 count 3");
    fill_to(4);   check_flags("R10 count 4");
    fill_to(253); check_flags("R10 count 253");
    fill_to(254); check_flags("R10 count 254");
    drain();

    // sequence restart: load 5, plain write cycle, load 9 -> almost-empty again
    wr_cycle(1'b1, 1'b1, 18'd5);
    wr_cycle(1'b1, 1'b0, 18'h01234);
    wr_cycle(1'b1, 1'b1, 18'd9);
    wr_idle();
    ae_exp = 9;
    settle();
    fill_to(9);   check_flags("R10 restart count 9");
    fill_to(10);  check_flags("R10 restart count 10");
    fill_to(254); check_flags("R10 restart afull kept");
    drain();

    // random mixed traffic, R2 ordering under contention
    fork
      begin
        for (int i = 0; i < 3000; i++)
          wr_cycle(($urandom % 3) != 0, 1'b0, DW'($urandom));
        wr_idle();
      end
      begin
        for (int i = 0; i < 1200; i++) begin
          bit oe = ($urandom % 4) != 0;
          rd_cycle(($urandom % 4) != 0, oe, "R2 random");
          if (!oe) check(rd_data_oe == 1'b0, "R6 random skip", rd_data_oe, 0);
        end
      end
    join
    settle();
    check_flags("after random");
    drain();
    check_flags("final");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule